// File: doc/BRIEF.md
# Port configuration lock controller

This block guards the configuration of one 16-pin I/O port. It holds a 17-bit register: a lock pattern in bits 15:0, with one bit per pin, and a lock-key flag in bit 16. Software reaches the register through a plain bus with a write strobe, a read strobe, 32-bit write data and 32-bit read data. While the port is unlocked, writes change the pattern freely. Three register writes in a row, with the key bit set to 1, then 0, then 1 and an identical pattern each time, arm the lock.

Once the lock is armed, the pattern is frozen and the key flag reads as 1 until reset. The block then drives a per-pin "configuration frozen" vector, which the port's other configuration registers use to block their own writes. Reset is synchronous and active low. It stands for both system reset and peripheral reset.

Top module: `pin_cfg_lock`

## Requirements
- R1: After reset, `rdata` is 0, `pin_frozen` is 0, and a read returns 0 (pattern 0, key flag 0).
- R2: While unlocked, every write loads `wdata[15:0]` into the pattern. A read issued in cycle N presents `{15'b0, key, pattern}` on `rdata` from cycle N+1.
- R3: Three consecutive writes with `wdata[16]` = 1, 0, 1 and equal `wdata[15:0]` arm the lock on the third write. After that write, reads return bit 16 = 1 and `pin_frozen` equals the pattern. No confirming read is needed.
- R4: If `wdata[15:0]` differs between the steps of a key sequence, the sequence aborts and no lock happens.
- R5: A write with `wdata[16]`=0 while the sequencer is idle or expects a 1 returns it to idle without locking.
- R6: A write with `wdata[16]`=1 while the sequencer expects 0 restarts the sequence, and that write counts as step one with its own pattern. A key-1 write that breaks step three by a pattern change also counts as step one.
- R7: Reads between the writes of a key sequence do not disturb it.
- R8: Once the lock is armed, writes leave the pattern and the key flag unchanged until reset.
- R9: `pin_frozen` is all zero while the lock is not armed.
- R10: Reset clears an armed lock, the pattern and the sequencer.
- R11: `rdata[31:17]` is always 0, and `rdata` holds its value in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Write data: bit 16 key, bits 15:0 pattern |
| rdata | output | 32 | Registered read data |
| pin_frozen | output | 16 | Per-pin configuration frozen flags |

## Verification
The hardest cases to reach are the near-miss key sequences: a third write whose pattern differs by one bit, and a key-1 write that arrives while the sequencer expects 0 and must restart it instead of aborting. Random stimulus draws patterns from a two-value pool and key bits from a coin toss, so these near misses occur often. Directed sequences also build each abort path explicitly, and the restart path is followed by a full lock. Occasional random resets let the run lock and unlock many times.

// File: rtl/pcl_pkg.sv
// Shared types for the port configuration lock controller.
package pcl_pkg;
    // Key sequencer position: which key value the next write must carry.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,  // waiting for key = 1 (step one)
        SEQ_WANT0 = 2'd1,  // step one seen, waiting for key = 0
        SEQ_WANT1 = 2'd2   // step two seen, waiting for key = 1
    } seq_state_t;
endpackage

// File: rtl/pcl_key_seq.sv
// Key sequencer: watches register writes for the 1,0,1 key pattern with an
// unchanged lock pattern and raises a sticky lock flag when it completes.
// Assumes at most one write per cycle; reads never reach this module.
module pcl_key_seq
    import pcl_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wkey,
    input  logic [NUM_PINS-1:0] wpat,
    output logic                locked
);
    seq_state_t          state_q, state_d;
    logic [NUM_PINS-1:0] pat_q, pat_d;
    logic                lock_d;

    // Next-state decision for one write.
    always_comb begin
        state_d = state_q;
        pat_d   = pat_q;
        lock_d  = locked;
        if (wr_en && !locked) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wkey) begin
                        state_d = SEQ_WANT0;
                        pat_d   = wpat;
                    end
                end
                SEQ_WANT0: begin
                    if (wkey) begin
                        state_d = SEQ_WANT0;
                        pat_d   = wpat;
                    end else if (wpat == pat_q) begin
                        state_d = SEQ_WANT1;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                SEQ_WANT1: begin
                    if (wkey && wpat == pat_q) begin
                        state_d = SEQ_IDLE;
                        lock_d  = 1'b1;
                    end else if (wkey) begin
                        state_d = SEQ_WANT0;
                        pat_d   = wpat;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Sequencer registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pat_q   <= '0;
            locked  <= 1'b0;
        end else begin
            state_q <= state_d;
            pat_q   <= pat_d;
            locked  <= lock_d;
        end
    end
endmodule

// File: rtl/pcl_lock_reg.sv
// Lock pattern store: keeps the per-pin lock bits, accepts writes only while
// unlocked, and gates the pattern with the lock flag into frozen outputs.
// Assumes the lock flag rises on the same edge as the final pattern write.
module pcl_lock_reg #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_PINS-1:0] wpat,
    input  logic                locked,
    output logic [NUM_PINS-1:0] lock_bits,
    output logic [NUM_PINS-1:0] pin_frozen
);
    // Pattern register, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_bits <= '0;
        end else if (wr_en && !locked) begin
            lock_bits <= wpat;
        end
    end

    // Per-pin frozen flag: pattern bit qualified by the lock flag.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pin_frozen[p] = lock_bits[p] & locked;
    end
endmodule

// File: rtl/pin_cfg_lock.sv
// Top of the port configuration lock controller: splits write data into key
// and pattern, hosts the sequencer and the pattern store, and registers read
// data on each read strobe. Assumes DATA_W > NUM_PINS.
module pin_cfg_lock #(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_PINS-1:0] pin_frozen
);
    localparam int KEY_POS = NUM_PINS;
    localparam int PAD_W   = DATA_W - NUM_PINS - 1;

    logic                lock_active;
    logic [NUM_PINS-1:0] lock_bits;

    pcl_key_seq #(.NUM_PINS(NUM_PINS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wkey   (wdata[KEY_POS]),
        .wpat   (wdata[NUM_PINS-1:0]),
        .locked (lock_active)
    );

    pcl_lock_reg #(.NUM_PINS(NUM_PINS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wpat       (wdata[NUM_PINS-1:0]),
        .locked     (lock_active),
        .lock_bits  (lock_bits),
        .pin_frozen (pin_frozen)
    );

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= {{PAD_W{1'b0}}, lock_active, lock_bits};
        end
    end
endmodule

// File: rtl/pcl_lock_chk.sv
// Assertion checker for pin_cfg_lock, attached by bind below.
module pcl_lock_chk #(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic [NUM_PINS-1:0] pin_frozen,
    input logic                lock_active,
    input logic [NUM_PINS-1:0] lock_bits
);
    a_r8_key_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> lock_active);

    a_r8_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> $stable(lock_bits));

    a_r3_lock_on_key_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> ($past(wr_en) && $past(wdata[NUM_PINS])));

    a_r2_pattern_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_bits) |-> ($past(wr_en) && !$past(lock_active)));

    a_r9_frozen_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_frozen != '0) |-> lock_active);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_PINS+1] == '0);
endmodule

bind pin_cfg_lock pcl_lock_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .pin_frozen  (pin_frozen),
    .lock_active (lock_active),
    .lock_bits   (lock_bits)
);

// File: tb/test_pin_cfg_lock.sv
// Bench for pin_cfg_lock: directed corner cases plus seeded random traffic,
// checked against a bench-side model of the register rules.
module test_pin_cfg_lock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pin_frozen;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [15:0] m_bits;
    logic        m_key;
    int          m_step;    // 0 idle, 1 expects key 0, 2 expects key 1
    logic [15:0] m_pat;
    logic [31:0] m_rdata;

    always #5 clk = ~clk;

    pin_cfg_lock i_pin_cfg_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_frozen(pin_frozen)
    );

    function automatic logic [31:0] exp_read();
        return {15'b0, m_key, m_bits};
    endfunction

    function automatic logic [15:0] exp_frozen();
        return m_key ? m_bits : 16'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        m_bits = '0; m_key = 1'b0; m_step = 0; m_pat = '0; m_rdata = '0;
    endtask

    // Model of one write, following R2..R8.
    task automatic model_write(input logic k, input logic [15:0] p);
        if (m_key) return;
        m_bits = p;
        case (m_step)
            0: if (k) begin m_step = 1; m_pat = p; end
            1: if (k) begin m_pat = p; end
               else if (p == m_pat) m_step = 2;
               else m_step = 0;
            default: if (k && p == m_pat) begin m_key = 1'b1; m_step = 0; end
                     else if (k) begin m_step = 1; m_pat = p; end
                     else m_step = 0;
        endcase
    endtask

    task automatic do_reset(input string req);
        @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
        check(req, rdata, 32'h0);
        check(req, {16'h0, pin_frozen}, 32'h0);
    endtask

    task automatic do_write(input string req, input logic k, input logic [15:0] p);
        @(negedge clk);
        wr_en = 1'b1; wdata = {$urandom_range(0, 1) ? 15'h0 : 15'h0, k, p};
        @(negedge clk);
        wr_en = 1'b0;
        model_write(k, p);
        check(req, {16'h0, pin_frozen}, {16'h0, exp_frozen()});
    endtask

    task automatic do_read(input string req);
        logic [31:0] e;
        @(negedge clk);
        rd_en = 1'b1; e = exp_read();
        @(negedge clk);
        rd_en = 1'b0;
        m_rdata = e;
        check(req, rdata, e);
    endtask

    // Watchdog: a hung run still reaches the summary line.
    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] pool [2];
        void'($urandom(32'd1234));
        model_reset();

        // R1: reset state.
        do_reset("R1");
        do_read("R1");

        // R2 and R9: plain writes while unlocked.
        do_write("R9", 1'b0, 16'hA5C3);
        do_read("R2");
        do_write("R9", 1'b0, 16'h0F0F);
        do_read("R2");

        // R4: pattern changes at step three.
        do_write("R4", 1'b1, 16'h1234);
        do_write("R4", 1'b0, 16'h1234);
        do_write("R4", 1'b1, 16'h1235);
        do_read("R4");
        // R4: pattern changes at step two.
        do_reset("R10");
        do_write("R4", 1'b1, 16'h00FF);
        do_write("R4", 1'b0, 16'h00FE);
        do_write("R4", 1'b1, 16'h00FE);
        do_read("R4");

        // R5: key 0 at step three aborts; following 1 is only step one.
        do_reset("R10");
        do_write("R5", 1'b1, 16'h4444);
        do_write("R5", 1'b0, 16'h4444);
        do_write("R5", 1'b0, 16'h4444);
        do_write("R5", 1'b1, 16'h4444);
        do_read("R5");

        // R6: restart by key 1 while 0 expected, then lock on the new pattern.
        do_reset("R10");
        do_write("R6", 1'b1, 16'hAAAA);
        do_write("R6", 1'b1, 16'hBBBB);
        do_write("R6", 1'b0, 16'hBBBB);
        do_write("R6", 1'b1, 16'hBBBB);
        do_read("R6");
        check("R6", {16'h0, pin_frozen}, 32'h0000BBBB);

        // R7 and R3: reads interleaved with a good sequence.
        do_reset("R10");
        do_write("R7", 1'b1, 16'h8001);
        do_read("R7");
        do_write("R7", 1'b0, 16'h8001);
        do_read("R7");
        do_write("R3", 1'b1, 16'h8001);
        check("R3", {16'h0, pin_frozen}, 32'h00008001);
        do_read("R3");
        check("R3", rdata, 32'h00018001);

        // R8: writes after lock are ignored.
        do_write("R8", 1'b0, 16'h0000);
        do_write("R8", 1'b1, 16'hFFFF);
        do_read("R8");
        check("R8", rdata, 32'h00018001);

        // R11: rdata holds without a read even as the state would differ.
        do_reset("R10");
        do_read("R11");
        do_write("R11", 1'b0, 16'h7777);
        @(negedge clk);
        check("R11", rdata, m_rdata);

        // R10: a lock is cleared by reset.
        do_write("R10", 1'b1, 16'h0003);
        do_write("R10", 1'b0, 16'h0003);
        do_write("R10", 1'b1, 16'h0003);
        do_reset("R10");
        do_read("R10");

        // Random traffic over a two-value pattern pool.
        for (int i = 0; i < 4000; i++) begin
            int op;
            if (i % 40 == 0) begin
                pool[0] = 16'($urandom);
                pool[1] = pool[0] ^ (16'h1 << $urandom_range(0, 15));
            end
            op = $urandom_range(0, 99);
            if (op < 2) do_reset("R10");
            else if (op < 30) do_read("R2");
            else do_write("R3", 1'($urandom_range(0, 1)),
                          pool[$urandom_range(0, 3) == 0 ? 1 : 0]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule